// File: doc/BRIEF.md
# BCD Calendar Alarm Comparator

This block stores a wake-up time as six BCD bytes: seconds, minutes, hours, day of month, month and two-digit year. It compares that value with the live calendar that a separate timekeeper supplies. The timekeeper presents the live calendar as one flat bus, with seconds in the lowest byte. It pulses a one-cycle strobe on the clock cycle in which that bus takes its new value. The compare is made only on that cycle. When all six bytes match exactly, the block emits a one-cycle event. The event sets a sticky status flag. An interrupt line is driven high while that flag is set and the alarm enable is on. The weekday is not part of the compare.

The host reaches eight byte locations through a simple write port and a combinational read port:

| Address | Meaning |
|---|---|
| 0 | seconds |
| 1 | minutes |
| 2 | hours |
| 3 | day |
| 4 | month |
| 5 | year |
| 6 | control byte; bit 0 is the alarm enable |
| 7 | status byte; bit 0 is the alarm flag, and writing 1 to it clears the flag |

The usual host sequence is:
1. Clear the enable.
2. Rewrite the six alarm bytes.
3. Set the enable again.

Because a match needs the strobe, rewriting the alarm bytes can never raise the interrupt by itself. While the enable is clear, it cannot raise the interrupt at all.

Enable and flag are held in one four-state machine. The state is packed as {flag, enable}.

| State | Flag | Enable | Interrupt |
|---|---|---|---|
| ST_IDLE | 0 | 0 | low |
| ST_ARMED | 0 | 1 | low |
| ST_LATCHED | 1 | 0 | low |
| ST_ASSERTED | 1 | 1 | high |

The machine moves between states as follows:
- A matching strobe moves ST_IDLE to ST_LATCHED and ST_ARMED to ST_ASSERTED.
- A control write of 1 moves ST_IDLE to ST_ARMED and ST_LATCHED to ST_ASSERTED.
- A control write of 0 moves ST_ARMED to ST_IDLE and ST_ASSERTED to ST_LATCHED.
- A status write with bit 0 set moves ST_LATCHED to ST_IDLE and ST_ASSERTED to ST_ARMED. This happens only when no matching strobe arrives in the same cycle; if one does, the flag stays set.
- Combined inputs in one cycle land on the state given by the resulting {flag, enable} pair.

Top module: `bcd_alarm_unit`

## Requirements
- R1: Addresses 0 to 5 hold the seconds, minutes, hours, day, month and year alarm bytes, in that order. Each is 8 bits wide. A read returns exactly the byte last written to that address.
- R2: A compare takes place only in a cycle where `tick_i` is high. A live value equal to the alarm, presented while `tick_i` is low, produces no event and leaves the flag unchanged.
- R3: An event requires all six bytes to be equal. Field i of `live_time_i` occupies bits [8i+7:8i]. Flipping any single bit of any one field produces no event.
- R4: A matching strobe in cycle N drives `alarm_evt_o` high for cycle N+1 only. In the same clock edge it sets the flag (address 7, bit 0), and the flag stays set on later cycles.
- R5: `irq_o` is high exactly when the flag and the enable (address 6, bit 0) are both 1. The enable reads back as written. Setting the enable while the flag is set raises `irq_o` in the next cycle.
- R6: A write to address 7 with bit 0 set clears the flag. A write to address 7 with bit 0 clear leaves the flag as it was.
- R7: While the enable is 0, a matching strobe still sets the flag, but `irq_o` stays low. Writing the alarm bytes while disabled never raises `irq_o`.
- R8: If a matching strobe and a clearing status write fall in the same cycle, the flag is set after that edge.
- R9: After reset, all alarm bytes, the enable, the flag, `alarm_evt_o` and `irq_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| tick_i | input | 1 | one-cycle strobe in the cycle the live calendar updates |
| live_time_i | input | 48 | live BCD calendar, seconds in the low byte, year in the high byte |
| wr_en_i | input | 1 | host write strobe |
| wr_addr_i | input | 3 | host write address |
| wr_data_i | input | 8 | host write data |
| rd_addr_i | input | 3 | host read address |
| rd_data_o | output | 8 | read data, combinational from `rd_addr_i` |
| alarm_evt_o | output | 1 | one-cycle match event |
| irq_o | output | 1 | alarm interrupt, the flag gated by the enable |

## Verification
The bench uses the default parameters: six 8-bit fields and a 3-bit address. With these values the single-bit mismatch sweep covers every bit position of every field, 48 cases in all. The small state machine can also be driven exhaustively. Every {enable, flag} starting pair is combined with a strobe present or absent and each of four host write operations. This includes the case where a clearing write and a match land in the same cycle.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;

    // State code is {flag, enable}; the encoding is relied on by the FSM.
    typedef enum logic [1:0] {
        ST_IDLE     = 2'b00,
        ST_ARMED    = 2'b01,
        ST_LATCHED  = 2'b10,
        ST_ASSERTED = 2'b11
    } alm_state_e;

    localparam int ENABLE_BIT = 0;
    localparam int FLAG_BIT   = 0;

endpackage

// File: rtl/bcd_alarm_regs.sv
module bcd_alarm_regs #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 6,
    parameter int ADDR_W     = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [FIELD_W-1:0]            wr_data_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    input  logic                          en_i,
    input  logic                          flag_i,
    output logic [NUM_FIELDS*FIELD_W-1:0] alarm_o,
    output logic                          ctl_wr_o,
    output logic                          ctl_val_o,
    output logic                          stat_clr_o,
    output logic [FIELD_W-1:0]            rd_data_o
);
    import bcd_alarm_pkg::*;

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_FIELDS + 1);

    logic [FIELD_W-1:0] fld_q [NUM_FIELDS];

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_field
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(gi);

        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                fld_q[gi] <= '0;
            end else if (wr_en_i && (wr_addr_i == MY_ADDR)) begin
                fld_q[gi] <= wr_data_i;
            end
        end

        assign alarm_o[gi*FIELD_W +: FIELD_W] = fld_q[gi];
    end

    // Host write decode towards the state machine.
    always_comb begin
        ctl_wr_o   = wr_en_i && (wr_addr_i == CTRL_ADDR);
        ctl_val_o  = wr_data_i[ENABLE_BIT];
        stat_clr_o = wr_en_i && (wr_addr_i == STAT_ADDR) && wr_data_i[FLAG_BIT];
    end

    // Read mux.
    always_comb begin
        rd_data_o = '0;
        for (int k = 0; k < NUM_FIELDS; k++) begin
            if (rd_addr_i == ADDR_W'(k)) begin
                rd_data_o = fld_q[k];
            end
        end
        if (rd_addr_i == CTRL_ADDR) begin
            rd_data_o[ENABLE_BIT] = en_i;
        end else if (rd_addr_i == STAT_ADDR) begin
            rd_data_o[FLAG_BIT] = flag_i;
        end
    end

endmodule

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 6
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] alarm_i,
    output logic                          hit_o,
    output logic                          evt_o
);

    logic [NUM_FIELDS-1:0] field_eq;

    for (genvar gi = 0; gi < NUM_FIELDS; gi++) begin : g_eq
        assign field_eq[gi] =
            (live_i[gi*FIELD_W +: FIELD_W] == alarm_i[gi*FIELD_W +: FIELD_W]);
    end

    assign hit_o = tick_i && (&field_eq);

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            evt_o <= 1'b0;
        end else begin
            evt_o <= hit_o;
        end
    end

endmodule

// File: rtl/bcd_alarm_fsm.sv
module bcd_alarm_fsm (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic hit_i,
    input  logic ctl_wr_i,
    input  logic ctl_val_i,
    input  logic stat_clr_i,
    output logic en_o,
    output logic flag_o,
    output logic irq_o
);
    import bcd_alarm_pkg::*;

    alm_state_e state_q, state_d;
    logic       en_nx, flag_nx;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: a match outranks a clear; control writes set the enable.
    always_comb begin
        en_nx   = 1'b0;
        flag_nx = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                en_nx   = ctl_wr_i && ctl_val_i;
                flag_nx = hit_i;
            end
            ST_ARMED: begin
                en_nx   = !(ctl_wr_i && !ctl_val_i);
                flag_nx = hit_i;
            end
            ST_LATCHED: begin
                en_nx   = ctl_wr_i && ctl_val_i;
                flag_nx = hit_i || !stat_clr_i;
            end
            ST_ASSERTED: begin
                en_nx   = !(ctl_wr_i && !ctl_val_i);
                flag_nx = hit_i || !stat_clr_i;
            end
            default: begin
                en_nx   = 1'b0;
                flag_nx = 1'b0;
            end
        endcase
        state_d = alm_state_e'({flag_nx, en_nx});
    end

    always_comb begin
        en_o   = 1'b0;
        flag_o = 1'b0;
        irq_o  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_ARMED: begin
                en_o = 1'b1;
            end
            ST_LATCHED: begin
                flag_o = 1'b1;
            end
            ST_ASSERTED: begin
                en_o   = 1'b1;
                flag_o = 1'b1;
                irq_o  = 1'b1;
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/bcd_alarm_unit.sv
module bcd_alarm_unit #(
    parameter int FIELD_W    = 8,
    parameter int NUM_FIELDS = 6,
    parameter int ADDR_W     = 3
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          tick_i,
    input  logic [NUM_FIELDS*FIELD_W-1:0] live_time_i,
    input  logic                          wr_en_i,
    input  logic [ADDR_W-1:0]             wr_addr_i,
    input  logic [FIELD_W-1:0]            wr_data_i,
    input  logic [ADDR_W-1:0]             rd_addr_i,
    output logic [FIELD_W-1:0]            rd_data_o,
    output logic                          alarm_evt_o,
    output logic                          irq_o
);

    localparam int TIME_W = NUM_FIELDS * FIELD_W;

    logic [TIME_W-1:0] alarm_w;
    logic              ctl_wr_w, ctl_val_w, stat_clr_w;
    logic              hit_w, en_w, flag_w;

    bcd_alarm_regs #(
        .FIELD_W   (FIELD_W),
        .NUM_FIELDS(NUM_FIELDS),
        .ADDR_W    (ADDR_W)
    ) regs_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .en_i      (en_w),
        .flag_i    (flag_w),
        .alarm_o   (alarm_w),
        .ctl_wr_o  (ctl_wr_w),
        .ctl_val_o (ctl_val_w),
        .stat_clr_o(stat_clr_w),
        .rd_data_o (rd_data_o)
    );

    bcd_alarm_cmp #(
        .FIELD_W   (FIELD_W),
        .NUM_FIELDS(NUM_FIELDS)
    ) cmp_i (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .tick_i (tick_i),
        .live_i (live_time_i),
        .alarm_i(alarm_w),
        .hit_o  (hit_w),
        .evt_o  (alarm_evt_o)
    );

    bcd_alarm_fsm fsm_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .hit_i     (hit_w),
        .ctl_wr_i  (ctl_wr_w),
        .ctl_val_i (ctl_val_w),
        .stat_clr_i(stat_clr_w),
        .en_o      (en_w),
        .flag_o    (flag_w),
        .irq_o     (irq_o)
    );

endmodule

// File: rtl/bcd_alarm_unit_chk.sv
module bcd_alarm_unit_chk #(
    parameter int NUM_FIELDS = 6,
    parameter int ADDR_W     = 3
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              tick_i,
    input logic              wr_en_i,
    input logic [ADDR_W-1:0] wr_addr_i,
    input logic              wr_bit0_i,
    input logic              hit_i,
    input logic              flag_i,
    input logic              evt_i,
    input logic              irq_i
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_FIELDS);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(NUM_FIELDS + 1);

    logic clr_wr, dis_wr;
    assign clr_wr = wr_en_i && (wr_addr_i == STAT_ADDR) && wr_bit0_i;
    assign dis_wr = wr_en_i && (wr_addr_i == CTRL_ADDR) && !wr_bit0_i;

    p_evt_needs_tick_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        evt_i |-> $past(tick_i));

    p_hit_sets_flag_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        hit_i |=> (evt_i && flag_i));

    p_flag_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (flag_i && !clr_wr) |=> flag_i);

    p_clear_flag_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (clr_wr && !hit_i) |=> !flag_i);

    p_disable_quiet_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        dis_wr |=> !irq_i);

    p_match_beats_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i && clr_wr) |=> flag_i);

endmodule

bind bcd_alarm_unit bcd_alarm_unit_chk #(
    .NUM_FIELDS(NUM_FIELDS),
    .ADDR_W    (ADDR_W)
) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick_i),
    .wr_en_i  (wr_en_i),
    .wr_addr_i(wr_addr_i),
    .wr_bit0_i(wr_data_i[0]),
    .hit_i    (hit_w),
    .flag_i   (flag_w),
    .evt_i    (alarm_evt_o),
    .irq_i    (irq_o)
);

// File: tb/bcd_alarm_unit_tb_top.sv
`timescale 1ns/1ps
module bcd_alarm_unit_tb_top;

    localparam int FW = 8;
    localparam int NF = 6;
    localparam int AW = 3;
    localparam int TW = NF * FW;
    localparam logic [AW-1:0] A_CTRL = 3'd6;
    localparam logic [AW-1:0] A_STAT = 3'd7;
    localparam logic [TW-1:0] ALM    = 48'h24_06_15_12_45_30;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick = 1'b0;
    logic [TW-1:0] live = '0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [FW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [FW-1:0] rd_data;
    logic          evt, irq;

    int nvec = 0;
    int nfail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    bcd_alarm_unit #(.FIELD_W(FW), .NUM_FIELDS(NF), .ADDR_W(AW)) dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .tick_i     (tick),
        .live_time_i(live),
        .wr_en_i    (wr_en),
        .wr_addr_i  (wr_addr),
        .wr_data_i  (wr_data),
        .rd_addr_i  (rd_addr),
        .rd_data_o  (rd_data),
        .alarm_evt_o(evt),
        .irq_o      (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nvec++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [FW-1:0] d);
        rd_addr = a;
        #0.1;
        d = rd_data;
    endtask

    // One clock: optional strobe with a live value, optional host write.
    task automatic step(input bit do_tick, input logic [TW-1:0] t,
                        input bit do_wr, input logic [AW-1:0] a, input logic [FW-1:0] d);
        tick    = do_tick;
        if (do_tick) live = t;
        wr_en   = do_wr;
        wr_addr = a;
        wr_data = d;
        @(posedge clk);
        #1;
        tick  = 1'b0;
        wr_en = 1'b0;
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [FW-1:0] d);
        step(1'b0, '0, 1'b1, a, d);
    endtask

    task automatic idle();
        step(1'b0, '0, 1'b0, '0, '0);
    endtask

    initial begin
        #500000;
        if (!done) begin
            nfail++;
            $display("FAIL R4 watchdog act=running exp=finished");
            $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
            $finish;
        end
    end

    initial begin
        logic [FW-1:0] v;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;

        // R9: reset state
        for (int a = 0; a < 8; a++) begin
            rd(AW'(a), v);
            chk("R9 reset reg", {24'd0, v}, 32'd0);
        end
        chk("R9 reset irq", {31'd0, irq}, 32'd0);
        chk("R9 reset evt", {31'd0, evt}, 32'd0);

        // R1: alarm bytes read back in place
        for (int f = 0; f < NF; f++) wr(AW'(f), ALM[f*FW +: FW]);
        for (int f = 0; f < NF; f++) begin
            rd(AW'(f), v);
            chk("R1 readback", {24'd0, v}, {24'd0, ALM[f*FW +: FW]});
        end
        wr(A_CTRL, 8'h01);
        rd(A_CTRL, v);
        chk("R5 enable readback", {31'd0, v[0]}, 32'd1);

        // R3: every single-bit mismatch in every field
        for (int f = 0; f < NF; f++) begin
            for (int b = 0; b < FW; b++) begin
                step(1'b1, ALM ^ (48'd1 << (f*FW + b)), 1'b0, '0, '0);
                chk("R3 mismatch evt", {31'd0, evt}, 32'd0);
                rd(A_STAT, v);
                chk("R3 mismatch flag", {31'd0, v[0]}, 32'd0);
            end
        end

        // R2: equal value without strobe
        live = ALM;
        idle();
        chk("R2 no tick evt", {31'd0, evt}, 32'd0);
        rd(A_STAT, v);
        chk("R2 no tick flag", {31'd0, v[0]}, 32'd0);

        // R4: matching strobe
        step(1'b1, ALM, 1'b0, '0, '0);
        chk("R4 evt", {31'd0, evt}, 32'd1);
        rd(A_STAT, v);
        chk("R4 flag", {31'd0, v[0]}, 32'd1);
        chk("R5 irq", {31'd0, irq}, 32'd1);
        idle();
        chk("R4 evt one cycle", {31'd0, evt}, 32'd0);
        rd(A_STAT, v);
        chk("R4 flag sticky", {31'd0, v[0]}, 32'd1);

        // R6: write 0 keeps, write 1 clears
        wr(A_STAT, 8'hFE);
        rd(A_STAT, v);
        chk("R6 write0 keeps", {31'd0, v[0]}, 32'd1);
        wr(A_STAT, 8'h01);
        rd(A_STAT, v);
        chk("R6 write1 clears", {31'd0, v[0]}, 32'd0);
        chk("R6 irq drops", {31'd0, irq}, 32'd0);

        // R7: disabled match and alarm rewrite
        wr(A_CTRL, 8'h00);
        wr(3'd0, 8'h31);
        chk("R7 rewrite irq", {31'd0, irq}, 32'd0);
        step(1'b1, {ALM[TW-1:FW], 8'h31}, 1'b0, '0, '0);
        rd(A_STAT, v);
        chk("R7 flag set", {31'd0, v[0]}, 32'd1);
        chk("R7 irq low", {31'd0, irq}, 32'd0);
        wr(A_CTRL, 8'h01);
        chk("R5 late enable irq", {31'd0, irq}, 32'd1);
        wr(3'd0, 8'h30);

        // R5 R6 R8: exhaustive state/input sweep
        for (int e0 = 0; e0 < 2; e0++) begin
            for (int f0 = 0; f0 < 2; f0++) begin
                for (int h = 0; h < 2; h++) begin
                    for (int op = 0; op < 4; op++) begin
                        bit en_x, fl_x;
                        wr(A_STAT, 8'h01);
                        if (f0 != 0) step(1'b1, ALM, 1'b0, '0, '0);
                        wr(A_CTRL, FW'(e0));
                        case (op)
                            1: step(h != 0, ALM, 1'b1, A_STAT, 8'h01);
                            2: step(h != 0, ALM, 1'b1, A_CTRL, 8'h01);
                            3: step(h != 0, ALM, 1'b1, A_CTRL, 8'h00);
                            default: step(h != 0, ALM, 1'b0, '0, '0);
                        endcase
                        en_x = (op == 2) ? 1'b1 : (op == 3) ? 1'b0 : (e0 != 0);
                        fl_x = (h != 0) || ((f0 != 0) && (op != 1));
                        chk("R4 sweep evt", {31'd0, evt}, {31'd0, h[0]});
                        rd(A_STAT, v);
                        if (op == 1 && h != 0)
                            chk("R8 match beats clear", {31'd0, v[0]}, {31'd0, fl_x});
                        else
                            chk("R6 sweep flag", {31'd0, v[0]}, {31'd0, fl_x});
                        rd(A_CTRL, v);
                        chk("R5 sweep enable", {31'd0, v[0]}, {31'd0, en_x});
                        chk("R5 sweep irq", {31'd0, irq}, {31'd0, en_x & fl_x});
                    end
                end
            end
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", nvec, nfail);
        $finish;
    end

endmodule